// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block supervises two reference clocks feeding a clock-generation path. Running on a monitoring clock, it samples each reference through a synchronizer and looks for level changes. A reference that shows no change for a programmable number of monitor cycles is declared stalled, and a sticky alarm flag for that input is raised.

When the reference currently in use is flagged and the other one is healthy, the controller moves the selection to the healthy input on its own. A manual override blocks this automatic move: the selection then follows the user select pin. Stall detection keeps running during override. Pulling the alarm reset low clears both alarms and aligns the selection with the select pin. The master reset returns everything to its idle state and holds the downstream divider enable low.

Top module: `refclk_failover`

## Requirements
- R1: The two synchronizer flops make a level change on ref0_i or ref1_i visible as an edge two monitor cycles after it is sampled. If an input shows no edge for STALL_CYCLES consecutive monitor cycles (default 8), its flag (bad0_o or bad1_o) becomes 1.
- R2: Once a flag is 1, it stays 1 while alarm_rst_ni is high, even if the reference toggles again.
- R3: While alarm_rst_ni is low, both flags read 0 after the next edge, and each input's stall count starts again from zero.
- R4: clk_sel_o reads 0 while input 0 is in use and 1 while input 1 is in use. While alarm_rst_ni is low, clk_sel_o takes the value of sel_i (0 selects input 0, 1 selects input 1) on the next edge.
- R5: With override_i low and alarm_rst_ni high, if the flag of the input in use is 1 and the other input's flag is 0, the selection moves to the other input on the edge after the flag is seen at the outputs.
- R6: With override_i low and both flags at 1, the selection does not change.
- R7: While override_i is high, no automatic switch occurs and clk_sel_o takes the value of sel_i on the next edge.
- R8: Stall detection and flag setting continue unchanged while override_i is high.
- R9: While rst_ni is low, both flags, clk_sel_o, ref_mux_o and div_en_o are 0. div_en_o becomes 1 on the first edge after rst_ni is released.
- R10: ref_mux_o always equals clk_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitoring clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| alarm_rst_ni | input | 1 | Active-low alarm clear and selection realign |
| ref0_i | input | 1 | Reference clock 0, sampled |
| ref1_i | input | 1 | Reference clock 1, sampled |
| sel_i | input | 1 | User select: 0 input 0, 1 input 1 |
| override_i | input | 1 | High disables automatic switching |
| bad0_o | output | 1 | Sticky stall alarm for input 0 |
| bad1_o | output | 1 | Sticky stall alarm for input 1 |
| clk_sel_o | output | 1 | Input currently in use |
| ref_mux_o | output | 1 | Select line for the reference multiplexer |
| div_en_o | output | 1 | Downstream divider enable |

## Verification
If a stall counter is off by one, a flag rises one cycle early or late relative to the last edge a reference showed, and that is visible within STALL_CYCLES plus three cycles of any stall. A corrupted selection state shows on clk_sel_o no later than the cycle after a flag, override or alarm reset event. A flag that fails to be sticky reappears as 0 as soon as a stalled reference resumes. The bench drives both references through randomized runs of toggling and stuck segments, and tracks flags and selection with a cycle model built from the requirements.

// File: rtl/refclk_pkg.sv
package refclk_pkg;
  localparam int unsigned NUM_REFS = 2;
  typedef logic [NUM_REFS-1:0] ref_vec_t;
endpackage

// File: rtl/ref_sync.sv
module ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= ref_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[s] <= 1'b0;
          else         chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= chain_q[STAGES-1];

  assign edge_o = chain_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/stall_mon.sv
module stall_mon #(
  parameter int unsigned STALL_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  input  logic edge_i,
  output logic bad_o
);
  localparam int unsigned CNT_W = (STALL_CYCLES > 1) ? $clog2(STALL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STALL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (!clr_ni) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else if (edge_i) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_TOP) begin
      bad_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bad_o = bad_q;

  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_q && clr_ni |=> bad_q);
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> !bad_q && cnt_q == '0);
  a_r1_edge_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> cnt_q == '0);
  a_r1_no_early_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_q && edge_i |=> !bad_q);
endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import refclk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clr_ni,
  input  logic     sel_i,
  input  logic     override_i,
  input  ref_vec_t bad_i,
  output logic     act_o,
  output logic     div_en_o
);
  logic act_q, div_en_q;
  logic cur_bad, alt_bad;

  assign cur_bad = bad_i[act_q];
  assign alt_bad = bad_i[~act_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      div_en_q <= 1'b0;
    end else begin
      div_en_q <= 1'b1;
      if (!clr_ni || override_i) act_q <= sel_i;
      else if (cur_bad && !alt_bad) act_q <= ~act_q;
    end
  end

  assign act_o    = act_q;
  assign div_en_o = div_en_q;

  a_r4_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> act_q == $past(sel_i));
  a_r7_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    override_i |=> act_q == $past(sel_i));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !override_i && (&bad_i) |=> $stable(act_q));
  a_r5_failover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !override_i && bad_i[act_q] && !bad_i[~act_q] |=> act_q != $past(act_q));
  a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !override_i && !bad_i[act_q] |=> $stable(act_q));
  a_r9_div_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> div_en_q);
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
  import refclk_pkg::*;
#(
  parameter int unsigned STALL_CYCLES = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_rst_ni,
  input  logic ref0_i,
  input  logic ref1_i,
  input  logic sel_i,
  input  logic override_i,
  output logic bad0_o,
  output logic bad1_o,
  output logic clk_sel_o,
  output logic ref_mux_o,
  output logic div_en_o
);
  ref_vec_t ref_in, edge_w, bad_w;
  logic     act_w;

  assign ref_in = {ref1_i, ref0_i};

  generate
    for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
      ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ref_i  (ref_in[i]),
        .edge_o (edge_w[i])
      );
      stall_mon #(.STALL_CYCLES(STALL_CYCLES)) u_mon (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_ni (alarm_rst_ni),
        .edge_i (edge_w[i]),
        .bad_o  (bad_w[i])
      );
    end
  endgenerate

  sel_ctrl u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_ni     (alarm_rst_ni),
    .sel_i      (sel_i),
    .override_i (override_i),
    .bad_i      (bad_w),
    .act_o      (act_w),
    .div_en_o   (div_en_o)
  );

  assign bad0_o    = bad_w[0];
  assign bad1_o    = bad_w[1];
  assign clk_sel_o = act_w;
  assign ref_mux_o = act_w;

  a_r10_mux_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_mux_o == clk_sel_o);
  a_r8_detect_in_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    override_i && alarm_rst_ni && bad0_o |=> bad0_o);
endmodule

// File: tb/refclk_failover_tb_top.sv
module refclk_failover_tb_top;
  localparam int unsigned TH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, arst_n = 1'b1, ref0 = 1'b0, ref1 = 1'b0, sel = 1'b0, ovr = 1'b0;
  logic bad0, bad1, csel, rmux, den;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // cycle model built from the requirements
  logic [1:0] m1, m2, m3, mbad, pbad;
  int         mcnt [2];
  logic       mact, mden, p_arst, p_ovr;

  always #10 clk = ~clk;

  refclk_failover #(.STALL_CYCLES(TH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .alarm_rst_ni(arst_n),
    .ref0_i(ref0), .ref1_i(ref1), .sel_i(sel), .override_i(ovr),
    .bad0_o(bad0), .bad1_o(bad1), .clk_sel_o(csel), .ref_mux_o(rmux), .div_en_o(den));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = '0; m2 = '0; m3 = '0; mbad = '0; pbad = '0;
      mcnt[0] = 0; mcnt[1] = 0; mact = 1'b0; mden = 1'b0;
      p_arst = 1'b1; p_ovr = 1'b0;
    end else begin
      logic [1:0] e;
      pbad = mbad; p_arst = arst_n; p_ovr = ovr;
      mden = 1'b1;
      if (!arst_n || ovr) mact = sel;
      else if (mbad[mact] && !mbad[~mact]) mact = ~mact;
      e = m2 ^ m3;
      for (int i = 0; i < 2; i++) begin
        if (!arst_n) begin mcnt[i] = 0; mbad[i] = 1'b0; end
        else if (e[i]) mcnt[i] = 0;
        else if (mcnt[i] == TH - 1) mbad[i] = 1'b1;
        else mcnt[i] = mcnt[i] + 1;
      end
      m3 = m2; m2 = m1; m1 = {ref1, ref0};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string bad_tag(input bit prev_set);
    if (!p_arst) return "R3 flag clear";
    if (p_ovr)   return "R8 detect under override";
    if (prev_set) return "R2 sticky flag";
    return "R1 stall detect";
  endfunction

  function automatic string sel_tag();
    if (!p_arst) return "R4 align to select";
    if (p_ovr)   return "R7 override follows select";
    if (&pbad)   return "R6 both bad hold";
    return "R5 failover";
  endfunction

  task automatic compare_all();
    chk(bad0 == mbad[0], bad_tag(pbad[0]), bad0, mbad[0]);
    chk(bad1 == mbad[1], bad_tag(pbad[1]), bad1, mbad[1]);
    chk(csel == mact, sel_tag(), csel, mact);
    chk(rmux == csel, "R10 mux equals indicator", rmux, csel);
    chk(den == mden, "R9 divider enable", den, mden);
  endtask

  int mode [2], hp [2], tc [2];

  task automatic step();
    @(negedge clk);
    compare_all();
    for (int i = 0; i < 2; i++) begin
      if (mode[i] == 1) begin
        tc[i]++;
        if (tc[i] >= hp[i]) begin
          tc[i] = 0;
          if (i == 0) ref0 = ~ref0; else ref1 = ~ref1;
        end
      end
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mode[0] = 1; mode[1] = 1; hp[0] = 2; hp[1] = 3; tc[0] = 0; tc[1] = 0;
    #5;
    // R9: reset state
    chk(bad0 == 1'b0 && bad1 == 1'b0, "R9 reset flags", {bad1, bad0}, 0);
    chk(csel == 1'b0 && rmux == 1'b0, "R9 reset select", csel, 0);
    chk(den == 1'b0, "R9 reset divider enable", den, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(20);
    // directed: input 0 stalls, failover to input 1 (R5)
    mode[0] = 0; run(TH + 6);
    chk(csel == 1'b1, "R5 directed failover", csel, 1);
    // R2: input 0 resumes, flag must stay
    mode[0] = 1; run(10);
    chk(bad0 == 1'b1, "R2 directed sticky", bad0, 1);
    // R6: input 1 stalls too, selection holds
    mode[1] = 0; run(TH + 6);
    chk(csel == 1'b1 && bad1 == 1'b1, "R6 directed hold", csel, 1);
    // R3/R4: alarm reset with sel=0
    sel = 1'b0; arst_n = 1'b0; run(2); arst_n = 1'b1;
    chk(bad0 == 1'b0 && bad1 == 1'b0 && csel == 1'b0, "R3 R4 directed clear", {csel, bad1, bad0}, 0);
    mode[1] = 1;
    // R7/R8: override with stalled active input, no switch, flag still sets
    ovr = 1'b1; sel = 1'b0; mode[0] = 0; run(TH + 6);
    chk(bad0 == 1'b1, "R8 directed flag under override", bad0, 1);
    chk(csel == 1'b0, "R7 directed no switch", csel, 0);
    ovr = 1'b0; run(3);
    chk(csel == 1'b1, "R5 failover after override drops", csel, 1);
    mode[0] = 1;
    // random phase
    for (int c = 0; c < 4000; c++) begin
      if (c % 37 == 0)
        for (int i = 0; i < 2; i++) begin
          mode[i] = ($urandom % 10 < 4) ? 0 : 1;
          hp[i] = 1 + ($urandom % (TH / 2));
        end
      if ($urandom % 30 == 0) sel = ~sel;
      if ($urandom % 80 == 0) ovr = ~ovr;
      arst_n = ($urandom % 50 == 0) ? 1'b0 : 1'b1;
      step();
    end
    // master reset in the middle of activity (R9)
    @(negedge clk); rst_n = 1'b0; #1;
    chk(bad0 == 1'b0 && bad1 == 1'b0 && csel == 1'b0 && den == 1'b0,
        "R9 master reset", {den, csel, bad1, bad0}, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule